// File: doc/BRIEF.md
# Host Access Port for a Time-Slot Switch

This block lets a host processor reach the memories of a 256-channel time-slot switch. The processor side is asynchronous in style: a 6-bit address, separate write and read data buses with an output enable standing in for a tristate data bus, an active-low select, an active-high strobe, a read/write line (high = read) and an active-low acknowledge that models an open-drain line. Select and strobe are brought into the 4.096 MHz switch clock domain through a synchronizer chain. The block then decodes the access.

An access with address bit 5 clear reaches a one-byte control word, and completes on the fast path. The control word holds three things: a memory selector, a stream number, and two mode bits. One mode bit is split mode. The other is broadcast-message mode, which is exported to the serial side. An access with address bit 5 set is a memory access. Address bits 4..0 give the channel, and the control word gives the stream and the target memory. A memory access is arbitrated against the serial path. The memory port is used only in a cycle that the serial side marks as free, and the acknowledge follows the memory transaction. The memories themselves are outside the block.

Top module: `cpu_port`

## Requirements
- R1: With addr[5]=0 the access goes to the control word whatever addr[4:0] holds. A write stores data bits 7,6,4,3,2,1,0, and a read returns them. Bit 5 of the control word always reads 0.
- R2: A control-word access drives ack_n low after the third rising clock edge that samples cs_n=0 and ds=1. It issues no mem_req.
- R3: With addr[5]=1 and split mode off, control bits 4:3 pick the memory: 01 = data memory, 10 = low connection memory, 11 = high connection memory. mem_sel carries the same code. mem_addr is {control bits 2:0 (stream), addr[4:0] (channel)}. Write data appears on mem_wdata with mem_we=1.
- R4: A write whose target is the data memory, and any access with selector 00, issues no mem_req and is acknowledged on the fast-path timing. A read with selector 00 returns 0.
- R5: When control bit 7 (split) is set, memory reads use mem_sel=01 and memory writes use mem_sel=10, whatever bits 4:3 hold.
- R6: A read of the high connection memory returns mem_rdata[2:0] with bits 7:3 forced to 0.
- R7: mem_req is asserted for exactly one cycle per memory access, and only in a cycle with slot_free=1. A memory write is acknowledged after the edge that completes the request. With the slot free throughout, that is the fourth edge.
- R8: A memory read samples mem_rdata in the cycle after the request. It is acknowledged on the fifth edge with the slot free throughout, and rdata returns the sampled byte.
- R9: ack_n stays low while cs_n=0 and ds=1 are held. It returns high after the third edge that samples the strobe released.
- R10: rdata_oe is 1 only while ack_n is low for a read access. It is never 1 on a write.
- R11: After reset: ack_n=1, rdata_oe=0, mem_req=0, control word 0, split_on=0, msg_all=0.
- R12: split_on follows control bit 7 and msg_all follows control bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4.096 MHz switch clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ds | input | 1 | Data strobe, active high |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Bit 5 chooses memory (1) or control word (0); bits 4:0 give the channel |
| wdata | input | 8 | Write data from the host |
| rdata | output | 8 | Read data to the host |
| rdata_oe | output | 1 | Drive enable for the host data bus |
| ack_n | output | 1 | Acknowledge, active low (open-drain pull-down) |
| slot_free | input | 1 | Serial side leaves the memory port idle this cycle |
| mem_req | output | 1 | Memory transaction strobe |
| mem_we | output | 1 | Transaction is a write |
| mem_sel | output | 2 | 01 data, 10 low connection, 11 high connection memory |
| mem_addr | output | 8 | {stream, channel} |
| mem_wdata | output | 8 | Write byte to the memory |
| mem_rdata | input | 8 | Read byte, valid the cycle after a read request |
| split_on | output | 1 | Split mode bit of the control word |
| msg_all | output | 1 | Broadcast-message bit of the control word |

## Verification
On every cycle the assertions check four things: that each memory access makes a single request, that no write ever targets the data memory, that split mode forces the memory choice, and that the acknowledge is held and released against the synchronized strobe. The latency of each access class, the stream and channel mapping over every location, the masking on high-memory reads, and the wait behind a busy serial slot rest on the bench's scenarios. Those scenarios compare against byte patterns that the bench computes.

// File: rtl/cpu_port_pkg.sv
package cpu_port_pkg;
    // Format of the control word and of the memory address
    localparam int CH_BITS   = 5;
    localparam int ST_BITS   = 3;
    localparam int MA_BITS   = CH_BITS + ST_BITS;
    localparam int BYTE_W    = 8;
    localparam int SPLIT_BIT = 7;
    localparam int BCAST_BIT = 6;
    localparam int SEL_LSB   = 3;

    typedef enum logic [1:0] {
        MS_NONE  = 2'b00,
        MS_DATA  = 2'b01,
        MS_CLOW  = 2'b10,
        MS_CHIGH = 2'b11
    } mem_sel_t;

    typedef enum logic [1:0] {
        AS_IDLE = 2'd0,
        AS_MEM  = 2'd1,
        AS_CAPT = 2'd2,
        AS_DONE = 2'd3
    } acc_state_t;
endpackage

// File: rtl/cpu_port_sync.sv
module cpu_port_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cpu_port_ctrl.sv
module cpu_port_ctrl
    import cpu_port_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [BYTE_W-1:0]  wr_byte,
    output logic [BYTE_W-1:0]  rd_byte,
    output logic               split_q,
    output logic               bcast_q,
    output mem_sel_t           sel_q,
    output logic [ST_BITS-1:0] stream_q
);
    typedef struct packed {
        logic               split;
        logic               bcast;
        mem_sel_t           sel;
        logic [ST_BITS-1:0] stream;
    } ctrl_t;

    ctrl_t cw_d, cw_q;
    logic  unused_bit5;

    assign unused_bit5 = wr_byte[5];

    always_comb begin
        cw_d = cw_q;
        if (wr_en) begin
            cw_d.split  = wr_byte[SPLIT_BIT];
            cw_d.bcast  = wr_byte[BCAST_BIT];
            cw_d.sel    = mem_sel_t'(wr_byte[SEL_LSB +: 2]);
            cw_d.stream = wr_byte[ST_BITS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cw_q <= '0;
        else        cw_q <= cw_d;
    end

    assign rd_byte  = {cw_q.split, cw_q.bcast, 1'b0, cw_q.sel, cw_q.stream};
    assign split_q  = cw_q.split;
    assign bcast_q  = cw_q.bcast;
    assign sel_q    = cw_q.sel;
    assign stream_q = cw_q.stream;
endmodule

// File: rtl/cpu_port.sv
module cpu_port
    import cpu_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         ds,
    input  logic         rd_wr,
    input  logic [5:0]   addr,
    input  logic [7:0]   wdata,
    output logic [7:0]   rdata,
    output logic         rdata_oe,
    output logic         ack_n,
    input  logic         slot_free,
    output logic         mem_req,
    output logic         mem_we,
    output logic [1:0]   mem_sel,
    output logic [7:0]   mem_addr,
    output logic [7:0]   mem_wdata,
    input  logic [7:0]   mem_rdata,
    output logic         split_on,
    output logic         msg_all
);
    localparam int HI_KEEP = 3;   // stored bits of a high connection location

    typedef struct packed {
        acc_state_t          st;
        logic                is_rd;
        mem_sel_t            sel;
        logic [MA_BITS-1:0]  maddr;
        logic [BYTE_W-1:0]   wd;
        logic [BYTE_W-1:0]   rd;
    } acc_t;

    acc_t               a_d, a_q;
    logic               sel_s;
    logic               ctrl_we;
    logic [BYTE_W-1:0]  ctrl_val;
    logic               c_split, c_bcast;
    mem_sel_t           c_sel;
    mem_sel_t           eff_sel;
    logic [ST_BITS-1:0] c_stream;

    cpu_port_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (~cs_n & ds),
        .q     (sel_s)
    );

    cpu_port_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctrl_we),
        .wr_byte  (wdata),
        .rd_byte  (ctrl_val),
        .split_q  (c_split),
        .bcast_q  (c_bcast),
        .sel_q    (c_sel),
        .stream_q (c_stream)
    );

    // Memory actually targeted: split mode overrides the selector
    always_comb begin
        if (c_split) eff_sel = rd_wr ? MS_DATA : MS_CLOW;
        else         eff_sel = c_sel;
    end

    always_comb begin
        a_d     = a_q;
        ctrl_we = 1'b0;
        unique case (a_q.st)
            AS_IDLE: begin
                if (sel_s) begin
                    a_d.is_rd = rd_wr;
                    a_d.wd    = wdata;
                    a_d.rd    = '0;
                    a_d.sel   = MS_NONE;
                    a_d.maddr = {c_stream, addr[CH_BITS-1:0]};
                    if (!addr[5]) begin
                        a_d.st = AS_DONE;
                        if (rd_wr) a_d.rd  = ctrl_val;
                        else       ctrl_we = 1'b1;
                    end else begin
                        a_d.sel = eff_sel;
                        if (eff_sel == MS_NONE || (eff_sel == MS_DATA && !rd_wr))
                            a_d.st = AS_DONE;
                        else
                            a_d.st = AS_MEM;
                    end
                end
            end
            AS_MEM: begin
                if (slot_free) a_d.st = a_q.is_rd ? AS_CAPT : AS_DONE;
            end
            AS_CAPT: begin
                if (a_q.sel == MS_CHIGH)
                    a_d.rd = {{(BYTE_W-HI_KEEP){1'b0}}, mem_rdata[HI_KEEP-1:0]};
                else
                    a_d.rd = mem_rdata;
                a_d.st = AS_DONE;
            end
            AS_DONE: begin
                if (!sel_s) a_d.st = AS_IDLE;
            end
            default: a_d.st = AS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign mem_req   = (a_q.st == AS_MEM) && slot_free;
    assign mem_we    = ~a_q.is_rd;
    assign mem_sel   = a_q.sel;
    assign mem_addr  = a_q.maddr;
    assign mem_wdata = a_q.wd;
    assign ack_n     = (a_q.st != AS_DONE);
    assign rdata     = a_q.rd;
    assign rdata_oe  = (a_q.st == AS_DONE) && a_q.is_rd;
    assign split_on  = c_split;
    assign msg_all   = c_bcast;
endmodule

// File: rtl/cpu_port_chk.sv
module cpu_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_s,
    input logic       ack_n,
    input logic       rdata_oe,
    input logic       mem_req,
    input logic       mem_we,
    input logic [1:0] mem_sel,
    input logic       split_on
);
    // R7: one request per memory access
    p_one_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R7: a memory write is acknowledged right after its request
    p_wr_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> !ack_n);

    // R4: the data memory is never written from the host
    p_no_dm_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_sel != 2'b01));

    // R5: split mode routes writes to the low connection memory
    p_split_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && split_on) |-> (mem_sel == 2'b10));

    // R5: split mode routes reads to the data memory
    p_split_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && split_on) |-> (mem_sel == 2'b01));

    // R9: acknowledge held while the strobe stays asserted
    p_ack_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && sel_s) |=> !ack_n);

    // R9: acknowledge released once the synchronized strobe drops
    p_ack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && !sel_s) |=> ack_n);

    // R10: data bus driven only inside an acknowledged access
    p_oe_acked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> !ack_n);
endmodule

bind cpu_port cpu_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_s    (sel_s),
    .ack_n    (ack_n),
    .rdata_oe (rdata_oe),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_sel  (mem_sel),
    .split_on (split_on)
);

// File: tb/cpu_port_test.sv
module cpu_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, ds = 1'b0, rd_wr = 1'b1;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rdata_oe, ack_n;
    logic       slot_free = 1'b1;
    logic       mem_req, mem_we;
    logic [1:0] mem_sel;
    logic [7:0] mem_addr, mem_wdata;
    logic [7:0] mem_rdata = '0;
    logic       split_on, msg_all;

    int checks = 0, errors = 0, req_cnt = 0, dm_wr_cnt = 0;
    logic done = 1'b0;

    logic [7:0] dm  [256];
    logic [7:0] cml [256];
    logic [7:0] cmh [256];

    always #4 clk = ~clk;

    cpu_port uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds(ds), .rd_wr(rd_wr),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .ack_n(ack_n), .slot_free(slot_free), .mem_req(mem_req),
        .mem_we(mem_we), .mem_sel(mem_sel), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .split_on(split_on), .msg_all(msg_all)
    );

    // Memory model standing in for the switch memories
    always @(posedge clk) begin
        if (mem_req) begin
            req_cnt <= req_cnt + 1;
            if (mem_we) begin
                case (mem_sel)
                    2'b01: begin dm[mem_addr] <= mem_wdata; dm_wr_cnt <= dm_wr_cnt + 1; end
                    2'b10: cml[mem_addr] <= mem_wdata;
                    2'b11: cmh[mem_addr] <= mem_wdata;
                    default: ;
                endcase
            end else begin
                case (mem_sel)
                    2'b01: mem_rdata <= dm[mem_addr];
                    2'b10: mem_rdata <= cml[mem_addr];
                    2'b11: mem_rdata <= cmh[mem_addr];
                    default: mem_rdata <= 8'hEE;
                endcase
            end
        end
    end

    function automatic logic [7:0] dm_pat(int i);
        return 8'((i * 13 + 7) ^ (i >> 3));
    endfunction
    function automatic logic [7:0] cl_pat(int s, int c);
        return 8'(s * 37 + c * 11 + 3);
    endfunction
    function automatic logic [7:0] ch_pat(int s, int c);
        return 8'((s * 7 + c) ^ 8'hA5);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    int lat, rel;
    logic [7:0] rv;
    logic oe;

    task automatic acc(input logic rd, input logic [5:0] a, input logic [7:0] wd);
        @(negedge clk);
        cs_n = 1'b0; ds = 1'b1; rd_wr = rd; addr = a; wdata = wd;
        lat = 0;
        while (ack_n && lat < 60) begin
            @(posedge clk); lat++; @(negedge clk);
        end
        rv = rdata; oe = rdata_oe;
        cs_n = 1'b1; ds = 1'b0;
        rel = 0;
        while (!ack_n && rel < 20) begin
            @(posedge clk); rel++; @(negedge clk);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int r0;
        for (int i = 0; i < 256; i++) begin
            dm[i] = dm_pat(i); cml[i] = '0; cmh[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11 reset state
        chk("R11 ack_n", ack_n, 1); chk("R11 oe", rdata_oe, 0);
        chk("R11 mem_req", mem_req, 0);
        chk("R11 split", split_on, 0); chk("R11 msg", msg_all, 0);
        acc(1'b1, 6'h00, 8'h00);
        chk("R11 ctrl read", rv, 8'h00);

        // R1 R2 R12: control word, bit 5 unstored, address low bits ignored
        r0 = req_cnt;
        acc(1'b0, 6'h1F, 8'hFF);
        chk("R2 ctrl write latency", lat, 3);
        chk("R10 oe on write", oe, 0);
        chk("R12 split", split_on, 1); chk("R12 msg", msg_all, 1);
        acc(1'b1, 6'h05, 8'h00);
        chk("R1 ctrl readback", rv, 8'hDF);
        chk("R2 ctrl read latency", lat, 3);
        chk("R10 oe on read", oe, 1);
        chk("R9 release latency", rel, 3);
        chk("R2 no mem_req", req_cnt - r0, 0);
        acc(1'b0, 6'h0A, 8'h4B);
        chk("R12 split off", split_on, 0); chk("R12 msg on", msg_all, 1);
        acc(1'b1, 6'h11, 8'h00);
        chk("R1 ctrl readback 2", rv, 8'h4B);

        // R3 R7: write every low connection location
        for (int s = 0; s < 8; s++) begin
            acc(1'b0, 6'h00, 8'(8'h10 | s));
            for (int c = 0; c < 32; c++) begin
                acc(1'b0, 6'(32 + c), cl_pat(s, c));
                chk("R7 write latency", lat, 4);
            end
        end
        // R3 R8: read them back
        for (int s = 0; s < 8; s++) begin
            acc(1'b0, 6'h00, 8'(8'h10 | s));
            for (int c = 0; c < 32; c++) begin
                acc(1'b1, 6'(32 + c), 8'h00);
                chk("R3 low conn read", rv, cl_pat(s, c));
                chk("R8 read latency", lat, 5);
            end
        end
        // R6: high connection memory, upper bits read 0
        for (int s = 0; s < 8; s++) begin
            acc(1'b0, 6'h00, 8'(8'h18 | s));
            for (int c = 0; c < 32; c++) acc(1'b0, 6'(32 + c), ch_pat(s, c));
            for (int c = 0; c < 32; c++) begin
                acc(1'b1, 6'(32 + c), 8'h00);
                chk("R6 high conn read", rv, ch_pat(s, c) & 8'h07);
            end
        end
        // R3: data memory reads
        for (int s = 0; s < 8; s++) begin
            acc(1'b0, 6'h00, 8'(8'h08 | s));
            for (int c = 0; c < 32; c += 3) begin
                acc(1'b1, 6'(32 + c), 8'h00);
                chk("R3 data mem read", rv, dm_pat(s * 32 + c));
            end
        end
        // R4: data memory write ignored, selector 00 gives 0
        acc(1'b0, 6'h00, 8'h0B);
        r0 = req_cnt;
        acc(1'b0, 6'h24, 8'h99);
        chk("R4 dm write latency", lat, 3);
        chk("R4 dm write no req", req_cnt - r0, 0);
        acc(1'b1, 6'h24, 8'h00);
        chk("R4 dm unchanged", rv, dm_pat(3 * 32 + 4));
        acc(1'b0, 6'h00, 8'h02);
        r0 = req_cnt;
        acc(1'b1, 6'h27, 8'h00);
        chk("R4 sel00 read value", rv, 0);
        chk("R4 sel00 latency", lat, 3);
        chk("R4 sel00 no req", req_cnt - r0, 0);

        // R5: split mode with selector pointing at high memory
        acc(1'b0, 6'h00, 8'h9A);
        acc(1'b0, 6'h27, 8'h3C);
        chk("R5 split write to low", cml[2 * 32 + 7], 8'h3C);
        chk("R5 high untouched", cmh[2 * 32 + 7], ch_pat(2, 7));
        acc(1'b1, 6'h27, 8'h00);
        chk("R5 split read from data", rv, dm_pat(2 * 32 + 7));
        chk("R4 no dm writes", dm_wr_cnt, 0);

        // R7: busy serial slot delays the request
        acc(1'b0, 6'h00, 8'h11);
        r0 = req_cnt;
        @(negedge clk);
        slot_free = 1'b0;
        cs_n = 1'b0; ds = 1'b1; rd_wr = 1'b0; addr = 6'h2D; wdata = 8'h77;
        repeat (8) @(negedge clk);
        chk("R7 waits for slot ack", ack_n, 1);
        chk("R7 waits for slot req", req_cnt - r0, 0);
        slot_free = 1'b1;
        @(negedge clk);
        chk("R7 ack after slot", ack_n, 0);
        chk("R7 single req", req_cnt - r0, 1);
        chk("R3 stored", cml[1 * 32 + 13], 8'h77);
        // R9: hold the strobe, acknowledge stays
        repeat (10) @(negedge clk);
        chk("R9 ack held", ack_n, 0);
        cs_n = 1'b1; ds = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 still low before sync", ack_n, 0);
        @(negedge clk);
        chk("R9 released", ack_n, 1);
        chk("R10 oe after release", rdata_oe, 0);

        finish_run();
    end
endmodule